// File: doc/BRIEF.md
# Ten-Input Group Reduction ALU

This block folds ten unsigned operands into one result in a single clock cycle. Nine operands are the partial results of a 3x3 processing-element array. The tenth comes from the sequencing controller. The operation applied to them is one of a small set of group operations: total, scaled total, minimum, maximum, bitwise AND, bitwise OR and a count of nonzero operands. The result is registered and goes to the write-back path.

Each operation is described by an 18-bit operation word. The word holds a 10-bit lane mask and an 8-bit instruction. A 16-entry local program store is filled one word per cycle through a serial load port. A shared compute strobe, which also starts the PE array, executes the word at the local program counter. The counter then advances by one. A direct-execution flag makes the block run a word supplied by the controller in that cycle instead, and the program counter does not move.

Top module: `grp_reduce_alu`

## Requirements
- R1: While reset is low and in the first cycle after it, res_valid and res_data read 0. The program counter, the load pointer and every store entry are cleared.
- R2: Each cycle with ld_en high writes ld_word into the store entry at the load pointer. The pointer then advances by one and wraps from 15 to 0. A word written in a cycle can be executed from the next cycle onward.
- R3: A cycle with exec_en high and exec_direct low executes the store entry at the program counter. The counter then advances by one and wraps from 15 to 0. A direct execution or an idle cycle leaves the counter unchanged.
- R4: A cycle with exec_en and exec_direct both high executes direct_word and leaves the store untouched.
- R5: res_valid is high in exactly the cycle after each cycle with exec_en high. res_data carries the new result in that cycle and holds it until the next execution.
- R6: Operation word layout: bits [17:8] are the lane mask, where bit 8+k selects PE lane k (pe_data[8k+7:8k]) for k=0..8 and bit 17 selects ctl_data. Bits [7:6] must be 00. Bits [5:3] are the opcode. Bits [2:0] are a shift amount.
- R7: Opcode 0 gives the unsigned sum of the selected operands as a 16-bit value.
- R8: Opcode 1 gives that sum shifted right by the shift field.
- R9: Opcode 2 gives the minimum and opcode 3 the maximum of the selected operands, zero-extended.
- R10: Opcode 4 gives the bitwise AND and opcode 5 the bitwise OR of the selected operands, zero-extended.
- R11: Opcode 6 gives the number of selected operands that are nonzero, in the range 0 to 10.
- R12: The result is 0 when the mask is empty, when the opcode is 7, or when bits [7:6] are not 00. res_valid still rises in these cases.
- R13: Operands whose mask bit is 0 have no effect on the result, whatever values they hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pe_data | input | 72 | Nine 8-bit PE-array operands, lane k at bits [8k+7:8k] |
| ctl_data | input | 8 | Controller operand, lane 9 |
| ld_en | input | 1 | Serial program-store write strobe |
| ld_word | input | 18 | Operation word to store |
| exec_en | input | 1 | Joint compute strobe |
| exec_direct | input | 1 | Execute direct_word instead of the stored word |
| direct_word | input | 18 | Operation word for direct execution |
| res_data | output | 16 | Registered group result |
| res_valid | output | 1 | High for one cycle after each execution |

## Verification
The hardest case to reach from the ports is a program-counter wrap that lands on an entry being rewritten in the same cycle. The design must run the old word and pick up the new one only on the next pass. To reach it, the stimulus keeps loading while it executes, so the load pointer and the counter drift relative to each other. The other hard case is a masked-off lane that holds 0x00 or 0xFF while the operation is minimum or AND, where such a lane would otherwise decide the result. To reach it, the stimulus sets unselected lanes to those values on purpose and also runs a long mixed random phase.

// File: rtl/grp_alu_pkg.sv
// Shared definitions for the group reduction ALU.
// Assumes the 8-bit instruction layout: [7:6] reserved, [5:3] opcode, [2:0] shift.
package grp_alu_pkg;
    localparam int INSTR_W = 8;

    typedef enum logic [2:0] {
        OP_SUM   = 3'd0,
        OP_SUMSH = 3'd1,
        OP_MIN   = 3'd2,
        OP_MAX   = 3'd3,
        OP_AND   = 3'd4,
        OP_OR    = 3'd5,
        OP_CNT   = 3'd6,
        OP_RSV   = 3'd7
    } grp_op_e;
endpackage

// File: rtl/grp_prog_store.sv
// Local program store with a serial load pointer and a program counter.
// Assumes a write and a read of the same entry in one cycle return the old word.
module grp_prog_store #(
    parameter int DEPTH = 16,
    parameter int WW    = 18,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_en,
    input  logic [WW-1:0] ld_word,
    input  logic          step,
    output logic [WW-1:0] rd_word,
    output logic [PW-1:0] pc_o
);
    logic [WW-1:0] mem_q [DEPTH];
    logic [PW-1:0] ld_ptr_q;
    logic [PW-1:0] pc_q;

    // Store writes, load pointer and program counter, all wrapping at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
            ld_ptr_q <= '0;
            pc_q     <= '0;
        end else begin
            if (ld_en) begin
                mem_q[ld_ptr_q] <= ld_word;
                ld_ptr_q <= (ld_ptr_q == PW'(DEPTH - 1)) ? '0 : ld_ptr_q + 1'b1;
            end
            if (step) begin
                pc_q <= (pc_q == PW'(DEPTH - 1)) ? '0 : pc_q + 1'b1;
            end
        end
    end

    // Word at the current program counter.
    always_comb rd_word = mem_q[pc_q];

    assign pc_o = pc_q;
endmodule

// File: rtl/grp_reduce.sv
// Combinational ten-lane group reduction under a lane mask.
// Assumes unsigned operands and a sum that fits in RW bits.
module grp_reduce
    import grp_alu_pkg::*;
#(
    parameter int NIN = 10,
    parameter int DW  = 8,
    parameter int RW  = 16,
    localparam int WW = NIN + INSTR_W
) (
    input  logic [NIN*DW-1:0] lanes,
    input  logic [WW-1:0]     word,
    output logic [RW-1:0]     result
);
    logic [NIN-1:0] mask;
    grp_op_e        op;
    logic [2:0]     sh;
    logic           bad;

    assign mask = word[WW-1:INSTR_W];
    assign op   = grp_op_e'(word[5:3]);
    assign sh   = word[2:0];
    assign bad  = (word[7:6] != 2'b00) || (mask == '0) || (op == OP_RSV);

    logic [DW-1:0]  pass_v [NIN];
    logic [DW-1:0]  ones_v [NIN];
    logic [NIN-1:0] nz;

    // Per lane: masked-off lanes become the identity for 0-based and all-ones-based folds.
    for (genvar g = 0; g < NIN; g++) begin : g_lane
        assign pass_v[g] = mask[g] ? lanes[g*DW +: DW] : '0;
        assign ones_v[g] = mask[g] ? lanes[g*DW +: DW] : '1;
        assign nz[g]     = mask[g] && (lanes[g*DW +: DW] != '0);
    end

    logic [RW-1:0] sum, cnt;
    logic [DW-1:0] mn, mx, an, orr;

    // Fold all lanes in parallel.
    always_comb begin
        sum = '0; cnt = '0; mn = '1; mx = '0; an = '1; orr = '0;
        for (int i = 0; i < NIN; i++) begin
            sum = sum + RW'(pass_v[i]);
            cnt = cnt + RW'(nz[i]);
            if (ones_v[i] < mn) mn = ones_v[i];
            if (pass_v[i] > mx) mx = pass_v[i];
            an  = an & ones_v[i];
            orr = orr | pass_v[i];
        end
    end

    // Pick the opcode's result; invalid or empty selections give zero.
    always_comb begin
        result = '0;
        if (!bad) begin
            unique case (op)
                OP_SUM:   result = sum;
                OP_SUMSH: result = sum >> sh;
                OP_MIN:   result = RW'(mn);
                OP_MAX:   result = RW'(mx);
                OP_AND:   result = RW'(an);
                OP_OR:    result = RW'(orr);
                OP_CNT:   result = cnt;
                default:  result = '0;
            endcase
        end
    end
endmodule

// File: rtl/grp_reduce_alu.sv
// Top: ten-input group ALU fed by a serially loaded local program or a direct word.
// Assumes exec_en is the compute strobe shared with the PE array; one result per strobe.
module grp_reduce_alu #(
    parameter int NPE   = 9,
    parameter int DW    = 8,
    parameter int RW    = 16,
    parameter int DEPTH = 16,
    localparam int NIN  = NPE + 1,
    localparam int WW   = NIN + 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPE*DW-1:0] pe_data,
    input  logic [DW-1:0]     ctl_data,
    input  logic              ld_en,
    input  logic [WW-1:0]     ld_word,
    input  logic              exec_en,
    input  logic              exec_direct,
    input  logic [WW-1:0]     direct_word,
    output logic [RW-1:0]     res_data,
    output logic              res_valid
);
    logic [WW-1:0] mem_word;
    logic [WW-1:0] act_word;
    logic [PW-1:0] cur_pc;
    logic [RW-1:0] red_out;
    logic          step;

    assign step     = exec_en && !exec_direct;
    assign act_word = exec_direct ? direct_word : mem_word;

    grp_prog_store #(.DEPTH(DEPTH), .WW(WW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_en   (ld_en),
        .ld_word (ld_word),
        .step    (step),
        .rd_word (mem_word),
        .pc_o    (cur_pc)
    );

    grp_reduce #(.NIN(NIN), .DW(DW), .RW(RW)) u_red (
        .lanes  ({ctl_data, pe_data}),
        .word   (act_word),
        .result (red_out)
    );

    // Register the result and raise valid for one cycle per execution.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_data  <= '0;
            res_valid <= 1'b0;
        end else begin
            res_valid <= exec_en;
            if (exec_en) res_data <= red_out;
        end
    end
endmodule

// File: rtl/grp_alu_chk.sv
// Temporal checks for grp_reduce_alu, attached by bind.
module grp_alu_chk #(
    parameter int NIN   = 10,
    parameter int RW    = 16,
    parameter int DEPTH = 16,
    parameter int PW    = 4,
    parameter int WW    = 18
) (
    input logic          clk,
    input logic          rst_n,
    input logic          exec_en,
    input logic          exec_direct,
    input logic [WW-1:0] act_word,
    input logic [PW-1:0] cur_pc,
    input logic          res_valid,
    input logic [RW-1:0] res_data
);
    AST_VALID_AFTER_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        exec_en |=> res_valid);                                               // R5
    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_en |=> !res_valid);                                             // R5
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_en |=> $stable(res_data));                                      // R5
    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && !exec_direct) |=>
            cur_pc == (($past(cur_pc) == PW'(DEPTH - 1)) ? '0 : $past(cur_pc) + 1'b1)); // R3
    AST_PC_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!exec_en || exec_direct) |=> $stable(cur_pc));                       // R3
    AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && act_word[WW-1:8] == '0) |=> res_data == '0);              // R12
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && act_word[7:3] == 5'b00110) |=> res_data <= RW'(NIN));     // R11
endmodule

bind grp_reduce_alu grp_alu_chk #(
    .NIN(NIN), .RW(RW), .DEPTH(DEPTH), .PW(PW), .WW(WW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .exec_direct(exec_direct),
    .act_word(act_word), .cur_pc(cur_pc), .res_valid(res_valid), .res_data(res_data)
);

// File: tb/grp_reduce_alu_tb.sv
module grp_reduce_alu_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [71:0] pe_data = '0;
    logic [7:0]  ctl_data = '0;
    logic        ld_en = 1'b0;
    logic [17:0] ld_word = '0;
    logic        exec_en = 1'b0;
    logic        exec_direct = 1'b0;
    logic [17:0] direct_word = '0;
    logic [15:0] res_data;
    logic        res_valid;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;   // 250 MHz

    grp_reduce_alu u_dut (
        .clk(clk), .rst_n(rst_n), .pe_data(pe_data), .ctl_data(ctl_data),
        .ld_en(ld_en), .ld_word(ld_word), .exec_en(exec_en),
        .exec_direct(exec_direct), .direct_word(direct_word),
        .res_data(res_data), .res_valid(res_valid)
    );

    // ---------------- reference model ----------------
    logic [17:0] m_mem [16];
    int          m_pc = 0;
    int          m_lp = 0;
    logic        exp_valid = 1'b0;
    logic [15:0] exp_data = '0;
    string       exp_tag = "R1";

    function automatic int lane_val(input logic [71:0] pe, input logic [7:0] ctl, input int k);
        if (k < 9) return int'(pe[k*8 +: 8]);
        return int'(ctl);
    endfunction

    function automatic logic [15:0] ref_eval(input logic [17:0] w, input logic [71:0] pe,
                                             input logic [7:0] ctl);
        int s = 0, mn = 255, mx = 0, an = 255, orv = 0, c = 0, n = 0;
        for (int k = 0; k < 10; k++) begin
            if (w[8+k]) begin
                int v = lane_val(pe, ctl, k);
                n++; s += v; orv |= v; an &= v;
                if (v < mn) mn = v;
                if (v > mx) mx = v;
                if (v != 0) c++;
            end
        end
        if (n == 0 || w[7:6] != 2'b00) return 16'd0;
        case (w[5:3])
            3'd0: return 16'(s);
            3'd1: return 16'(s >> w[2:0]);
            3'd2: return 16'(mn);
            3'd3: return 16'(mx);
            3'd4: return 16'(an);
            3'd5: return 16'(orv);
            3'd6: return 16'(c);
            default: return 16'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [17:0] w, input logic dir);
        string t;
        t = dir ? "R4 R6" : "R2 R3 R6";
        if (w[17:8] == '0 || w[7:6] != 2'b00) t = {t, " R12"};
        else begin
            case (w[5:3])
                3'd0: t = {t, " R7"};
                3'd1: t = {t, " R8"};
                3'd2, 3'd3: t = {t, " R9"};
                3'd4, 3'd5: t = {t, " R10"};
                3'd6: t = {t, " R11"};
                default: t = {t, " R12"};
            endcase
        end
        if (w[17:8] != 10'h3FF) t = {t, " R13"};
        return t;
    endfunction

    // Model step at each rising edge: execution reads before the load writes.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) m_mem[i] = '0;
            m_pc = 0; m_lp = 0;
            exp_valid = 1'b0; exp_data = '0; exp_tag = "R1";
        end else begin
            exp_valid = exec_en;
            if (exec_en) begin
                logic [17:0] w;
                w = exec_direct ? direct_word : m_mem[m_pc];
                exp_data = ref_eval(w, pe_data, ctl_data);
                exp_tag  = tag_of(w, exec_direct);
                if (!exec_direct) m_pc = (m_pc + 1) % 16;
            end else if (exp_tag != "R1") begin
                exp_tag = "R5 hold";
            end
            if (ld_en) begin
                m_mem[m_lp] = ld_word;
                m_lp = (m_lp + 1) % 16;
            end
        end
    end

    // Compare every cycle, shortly after the edge.
    always @(posedge clk) begin
        #1;
        checks++;
        if (res_valid !== exp_valid) begin
            errors++;
            $display("FAIL R5 res_valid actual=%0b expected=%0b (%s)", res_valid, exp_valid, exp_tag);
        end
        checks++;
        if (res_data !== exp_data) begin
            errors++;
            $display("FAIL %s res_data actual=%0d expected=%0d", exp_tag, res_data, exp_data);
        end
    end

    // ---------------- stimulus ----------------
    task automatic cyc(input logic ld, input logic [17:0] lw, input logic ex,
                       input logic dir, input logic [17:0] dw);
        @(negedge clk);
        ld_en = ld; ld_word = lw; exec_en = ex; exec_direct = dir; direct_word = dw;
    endtask

    task automatic set_data(input logic [71:0] pe, input logic [7:0] ctl);
        pe_data = pe; ctl_data = ctl;
    endtask

    function automatic logic [17:0] mk(input logic [9:0] m, input logic [1:0] r,
                                       input logic [2:0] op, input logic [2:0] sh);
        return {m, r, op, sh};
    endfunction

    bit done = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;   // R1: reset state compared on every cycle above
        // R2: serial load of 16 entries covering every opcode and mask corner
        for (int i = 0; i < 16; i++) begin
            logic [9:0] m;
            m = (i == 9) ? 10'h000 : (i >= 8 ? (10'h2A5 ^ 10'(i)) : 10'h3FF);
            cyc(1'b1, mk(m, (i == 15) ? 2'b01 : 2'b00, 3'(i), 3'(i) ^ 3'd5),
                1'b0, 1'b0, '0);
        end
        cyc(1'b0, '0, 1'b0, 1'b0, '0);
        // R3: 20 stored executions, wrapping the program counter
        for (int i = 0; i < 20; i++) begin
            set_data({$urandom, $urandom, $urandom}, 8'($urandom));
            cyc(1'b0, '0, 1'b1, 1'b0, '0);
            if (i % 3 == 0) cyc(1'b0, '0, 1'b0, 1'b0, '0);
        end
        // R13: masked-off lanes hold extremes for min/and/max/or
        set_data({8'h00, 8'hFF, 8'h00, 8'hFF, 8'h00, 8'hFF, 8'h00, 8'h40, 8'h50}, 8'hFF);
        for (int op = 0; op < 7; op++)
            cyc(1'b0, '0, 1'b1, 1'b1, mk(10'h003, 2'b00, 3'(op), 3'd1));
        // R7 R9 R10: all operands 0xFF, then all zero, then controller lane only
        set_data({9{8'hFF}}, 8'hFF);
        for (int op = 0; op < 8; op++)
            cyc(1'b0, '0, 1'b1, 1'b1, mk(10'h3FF, 2'b00, 3'(op), 3'd3));
        set_data('0, 8'h00);
        for (int op = 0; op < 7; op++)
            cyc(1'b0, '0, 1'b1, 1'b1, mk(10'h3FF, 2'b00, 3'(op), 3'd0));
        set_data({9{8'h11}}, 8'hA7);
        for (int op = 0; op < 7; op++)
            cyc(1'b0, '0, 1'b1, 1'b1, mk(10'h200, 2'b00, 3'(op), 3'd2));
        // R12: empty mask and reserved bits
        cyc(1'b0, '0, 1'b1, 1'b1, mk(10'h000, 2'b00, 3'd2, 3'd0));
        cyc(1'b0, '0, 1'b1, 1'b1, mk(10'h3FF, 2'b10, 3'd0, 3'd0));
        cyc(1'b0, '0, 1'b0, 1'b0, '0);
        // R2 R3: loads racing stored execution, including same-entry overlap
        for (int i = 0; i < 40; i++) begin
            set_data({$urandom, $urandom, $urandom}, 8'($urandom));
            cyc(1'b1, mk(10'($urandom), 2'b00, 3'($urandom), 3'($urandom)),
                1'b1, 1'b0, '0);
        end
        // Mixed random phase
        for (int i = 0; i < 400; i++) begin
            logic [17:0] rw;
            rw = 18'($urandom);
            if (rw[7:6] != 2'b00 && rw[0]) rw[7:6] = 2'b00;
            set_data({$urandom, $urandom, $urandom}, 8'($urandom));
            cyc(1'($urandom), 18'($urandom), 1'($urandom), 1'($urandom), rw);
        end
        cyc(1'b0, '0, 1'b0, 1'b0, '0);
        repeat (3) @(negedge clk);
        done = 1'b1;
    end

    // Finish or watchdog, both ending with the summary line.
    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++;
                $display("FAIL watchdog expired actual=hung expected=done");
            end
        join_any
        @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule